// File: doc/BRIEF.md
# Two-Way Cache Tag Controller with Way Locking

This block holds the tags and the control state of a 16KB two-way set-associative cache with 32-byte lines, which gives 256 sets. The set is chosen by bits of the virtual address. The tag is compared with the translated physical page number one cycle later, so address translation can run alongside the tag read. In the compare cycle the block reports hit or miss, the hit way and the 64-bit doubleword that the data macro returns for that way. On a cacheable miss it chooses a victim way, requests a refill and installs the new tag there.

Each stored tag carries an even parity bit. Each 32-bit word returned by the data macro carries its own parity bit. A parity mismatch turns the lookup into a miss, raises an error pulse and steers the refill onto the damaged line. A lock input reserves way 0. While the lock is held, refills go only to way 1, so lines already resident in way 0 stay in place. A lookup marked uncached reads the tags but changes no state. The refill bus engine and the data RAM macros sit outside the block.

Top module: `vipt2w_tag_ctrl`

## Requirements
- R1: When `req_vld` is high at a clock edge, the result appears in the next cycle. `lk_hit` is high there if a valid entry of the indexed set has correct parity and its tag equals `cmp_ptag`, `cmp_uncached` is low and no parity error is seen. `lk_way` then gives that way and `rd_dw` gives that way's doubleword (bits [w*64 +: 64] of `dw_data`). Otherwise `lk_miss` is high.
- R2: A cacheable lookup that does not hit raises `refill_req` and installs `cmp_ptag` in way `refill_way`. A lookup of the same set and tag issued in the very next cycle hits in that way.
- R3: With no lock and no parity error, the victim is the lowest-numbered invalid way. If both ways are valid, the victim is the least recently used way. A hit makes the other way least recently used, and so does a fill.
- R4: While `lock_en` is high and no parity error is seen, the victim is always way 1. A line held in way 0 is never replaced and keeps hitting.
- R5: A lookup with `cmp_uncached` high reports a miss with no refill. It changes no tag, valid bit or LRU state.
- R6: The stored tag parity is the XOR of the 24 tag bits. An error is a mismatch on a valid entry. It forces a miss and raises `lk_err` for one cycle. The victim is then the way whose tag matched cleanly if there is one, else the lowest way with a tag error. This holds even while locked.
- R7: Bit 2*w+j of `dw_par` is the XOR of word j (bits [w*64+32*j +: 32]) of `dw_data`. A mismatch in the matched way forces a miss, raises `lk_err` and refills that same way.
- R8: After reset every line is invalid and every LRU bit points to way 0.
- R9: In a cycle with no lookup in the compare stage, `lk_hit`, `lk_miss`, `lk_err` and `refill_req` are low.

## Ports
| Port | Direction | Width | Description |
|------|-----------|-------|-------------|
| clk | input | 1 | Clock |
| rst_n | input | 1 | Synchronous active-low reset |
| req_vld | input | 1 | Start a lookup this edge |
| req_vidx | input | 8 | Set index taken from virtual address bits |
| cmp_ptag | input | 24 | Physical page tag, presented in the compare cycle |
| cmp_uncached | input | 1 | Compare-cycle attribute: do not allocate |
| lock_en | input | 1 | Reserve way 0 against replacement |
| fill_par_flip | input | 1 | Store the inverted tag parity on this fill (fault injection) |
| dw_data | input | 128 | Doubleword read from each way's data macro |
| dw_par | input | 4 | One parity bit per 32-bit word of `dw_data` |
| lk_hit | output | 1 | Lookup hit |
| lk_miss | output | 1 | Lookup missed |
| lk_way | output | 1 | Way that hit |
| lk_err | output | 1 | Parity error seen on this lookup |
| refill_req | output | 1 | Refill requested for this set |
| refill_way | output | 1 | Way chosen for the refill |
| rd_dw | output | 64 | Doubleword from the hit way |

## Verification
A tag install from a refill and a new lookup of the same set can land on the same clock edge. The fill is written at the end of one compare cycle, while the next request's tag read is captured at that same edge. The bench provokes this by issuing lookups back to back, with the second one aimed at the set that has just been filled, both in directed pairs and in a random stream limited to a few sets and tags. It judges the result against a bench model that applies each fill before it evaluates the following lookup. The second lookup must therefore hit in the way just written, with the LRU state that the fill left behind.

// File: rtl/vipt2w_pkg.sv
`timescale 1ns/1ps
// Shared constants and helpers for the two-way tag controller.
// Assumes two ways and a 64-bit data path split into 32-bit parity words.
package vipt2w_pkg;
    localparam int WAYS      = 2;
    localparam int DW_BITS   = 64;
    localparam int WORD_BITS = 32;
    localparam int WORDS_DW  = DW_BITS / WORD_BITS;

    // Even parity over one word: the stored bit equals the XOR of the word.
    function automatic logic word_parity(input logic [WORD_BITS-1:0] w);
        return ^w;
    endfunction
endpackage

// File: rtl/vipt2w_tag_way.sv
`timescale 1ns/1ps
// One way of the tag store. The tag and its parity are captured at the request
// edge, with a bypass from a fill written at that same edge. The valid bits are
// read in the compare cycle. Outputs a clean match and a parity error flag.
// Assumes at most one fill per cycle, issued from the compare stage.
module vipt2w_tag_way #(
    parameter int IDX_W = 8,
    parameter int TAG_W = 24,
    localparam int SETS = 1 << IDX_W
) (
    input  logic             clk,
    input  logic             rst_n,
    input  logic             rd_en,
    input  logic [IDX_W-1:0] rd_idx,
    input  logic [IDX_W-1:0] cmp_idx,
    input  logic [TAG_W-1:0] cmp_tag,
    input  logic             wr_en,
    input  logic [IDX_W-1:0] wr_idx,
    input  logic [TAG_W-1:0] wr_tag,
    input  logic             wr_flip,
    output logic             entry_vld,
    output logic             tag_match,
    output logic             tag_perr
);
    logic [TAG_W-1:0] tag_mem [SETS];
    logic             par_mem [SETS];
    logic [SETS-1:0]  vld_q;
    logic [TAG_W-1:0] s_tag;
    logic             s_par;
    logic             wr_par;

    assign wr_par = (^wr_tag) ^ wr_flip;

    // Tag and parity storage, written on fill.
    always_ff @(posedge clk) begin
        if (wr_en) begin
            tag_mem[wr_idx] <= wr_tag;
            par_mem[wr_idx] <= wr_par;
        end
    end

    // Valid bits: cleared by reset, set by fill.
    always_ff @(posedge clk) begin
        if (!rst_n)     vld_q <= '0;
        else if (wr_en) vld_q[wr_idx] <= 1'b1;
    end

    // Request-stage read with bypass of a same-edge fill.
    always_ff @(posedge clk) begin
        if (!rst_n) begin
            s_tag <= '0;
            s_par <= 1'b0;
        end else if (rd_en) begin
            if (wr_en && wr_idx == rd_idx) begin
                s_tag <= wr_tag;
                s_par <= wr_par;
            end else begin
                s_tag <= tag_mem[rd_idx];
                s_par <= par_mem[rd_idx];
            end
        end
    end

    // Compare-stage evaluation of validity, parity and match.
    always_comb begin
        entry_vld = vld_q[cmp_idx];
        tag_perr  = entry_vld && ((^s_tag) != s_par);
        tag_match = entry_vld && !tag_perr && (s_tag == cmp_tag);
    end

    // R6
    assert property (@(posedge clk) disable iff (!rst_n)
        !entry_vld |-> !tag_perr && !tag_match) else $error("invalid_entry_quiet_chk");
endmodule

// File: rtl/vipt2w_dw_parity.sv
`timescale 1ns/1ps
// Checks the per-word parity of the doubleword each way's data macro returns.
// Assumes the parity bits are packed way by way, word 0 lowest.
module vipt2w_dw_parity #(
    parameter int WAYS   = vipt2w_pkg::WAYS,
    parameter int WORDS  = vipt2w_pkg::WORDS_DW,
    parameter int WORD_W = vipt2w_pkg::WORD_BITS
) (
    input  logic [WAYS*WORDS*WORD_W-1:0] dw_data,
    input  logic [WAYS*WORDS-1:0]        dw_par,
    output logic [WAYS-1:0]              way_bad
);
    for (genvar w = 0; w < WAYS; w++) begin : g_way
        logic [WORDS-1:0] word_bad;
        for (genvar j = 0; j < WORDS; j++) begin : g_word
            // Compare recomputed word parity with the stored bit.
            assign word_bad[j] = vipt2w_pkg::word_parity(dw_data[(w*WORDS+j)*WORD_W +: WORD_W])
                                 != dw_par[w*WORDS+j];
        end
        assign way_bad[w] = |word_bad;
    end
endmodule

// File: rtl/vipt2w_victim.sv
`timescale 1ns/1ps
// Victim choice and per-set LRU state. An error overrides everything: the
// clean-matching way wins, else the lowest damaged way. A lock forces the free
// way. Otherwise an invalid way is taken first, then the LRU way.
// Assumes two ways, so one LRU bit per set names the least recent way.
module vipt2w_victim #(
    parameter int IDX_W    = 8,
    parameter int LOCK_WAY = 0,
    localparam int SETS    = 1 << IDX_W
) (
    input  logic             clk,
    input  logic             rst_n,
    input  logic [IDX_W-1:0] idx,
    input  logic [1:0]       way_vld,
    input  logic [1:0]       way_tperr,
    input  logic             any_match,
    input  logic             match_way,
    input  logic             err_any,
    input  logic             lock_en,
    input  logic             upd_hit,
    input  logic             upd_fill,
    output logic             victim
);
    localparam logic FREE_WAY = ~LOCK_WAY[0];
    logic [SETS-1:0] lru_q;

    // Select the replacement way for the compare-stage set.
    always_comb begin
        if (err_any)          victim = any_match ? match_way : (way_tperr[0] ? 1'b0 : 1'b1);
        else if (lock_en)     victim = FREE_WAY;
        else if (!way_vld[0]) victim = 1'b0;
        else if (!way_vld[1]) victim = 1'b1;
        else                  victim = lru_q[idx];
    end

    // Point LRU away from the way just used by a fill or a hit.
    always_ff @(posedge clk) begin
        if (!rst_n)        lru_q <= '0;
        else if (upd_fill) lru_q[idx] <= ~victim;
        else if (upd_hit)  lru_q[idx] <= ~match_way;
    end

    // R4
    assert property (@(posedge clk) disable iff (!rst_n)
        upd_fill && lock_en && !err_any |-> victim != LOCK_WAY[0]) else $error("lock_respected_chk");
    // R3
    assert property (@(posedge clk) disable iff (!rst_n)
        upd_hit && !upd_fill |=> lru_q[$past(idx)] != $past(match_way)) else $error("lru_after_hit_chk");
endmodule

// File: rtl/vipt2w_tag_ctrl.sv
`timescale 1ns/1ps
// Tag and control logic of a virtually indexed, physically tagged two-way cache.
// Cycle 0: set index captured, tags read. Cycle 1: physical tag compared, result,
// victim and refill request reported; the fill is written at the end of cycle 1.
// Assumes the data macros present both ways' doubleword in cycle 1.
module vipt2w_tag_ctrl #(
    parameter int CACHE_BYTES = 16384,
    parameter int LINE_BYTES  = 32,
    parameter int PA_W        = 36,
    parameter int PAGE_BITS   = 12,
    parameter int LOCK_WAY    = 0,
    localparam int WAYS  = vipt2w_pkg::WAYS,
    localparam int DW    = vipt2w_pkg::DW_BITS,
    localparam int WPD   = vipt2w_pkg::WORDS_DW,
    localparam int SETS  = CACHE_BYTES / (WAYS * LINE_BYTES),
    localparam int IDX_W = $clog2(SETS),
    localparam int TAG_W = PA_W - PAGE_BITS
) (
    input  logic                 clk,
    input  logic                 rst_n,
    input  logic                 req_vld,
    input  logic [IDX_W-1:0]     req_vidx,
    input  logic [TAG_W-1:0]     cmp_ptag,
    input  logic                 cmp_uncached,
    input  logic                 lock_en,
    input  logic                 fill_par_flip,
    input  logic [WAYS*DW-1:0]   dw_data,
    input  logic [WAYS*WPD-1:0]  dw_par,
    output logic                 lk_hit,
    output logic                 lk_miss,
    output logic                 lk_way,
    output logic                 lk_err,
    output logic                 refill_req,
    output logic                 refill_way,
    output logic [DW-1:0]        rd_dw
);
    logic             s1_vld;
    logic [IDX_W-1:0] s1_idx;
    logic [WAYS-1:0]  way_vld, way_match, way_tperr, way_dbad, way_wr;
    logic             any_match, match_way, dperr, err_any, victim;

    // Request stage register.
    always_ff @(posedge clk) begin
        if (!rst_n) begin
            s1_vld <= 1'b0;
            s1_idx <= '0;
        end else begin
            s1_vld <= req_vld;
            s1_idx <= req_vidx;
        end
    end

    for (genvar w = 0; w < WAYS; w++) begin : g_way
        assign way_wr[w] = refill_req && (victim == 1'(w));
        vipt2w_tag_way #(.IDX_W(IDX_W), .TAG_W(TAG_W)) u_way (
            .clk(clk), .rst_n(rst_n),
            .rd_en(req_vld), .rd_idx(req_vidx),
            .cmp_idx(s1_idx), .cmp_tag(cmp_ptag),
            .wr_en(way_wr[w]), .wr_idx(s1_idx), .wr_tag(cmp_ptag), .wr_flip(fill_par_flip),
            .entry_vld(way_vld[w]), .tag_match(way_match[w]), .tag_perr(way_tperr[w])
        );
    end

    vipt2w_dw_parity u_dpar (.dw_data(dw_data), .dw_par(dw_par), .way_bad(way_dbad));

    // Resolve the compare-stage outcome.
    always_comb begin
        any_match  = |way_match;
        match_way  = way_match[0] ? 1'b0 : 1'b1;
        dperr      = any_match && way_dbad[match_way];
        err_any    = (|way_tperr) || dperr;
        lk_hit     = s1_vld && !cmp_uncached && any_match && !err_any;
        lk_miss    = s1_vld && !lk_hit;
        lk_err     = s1_vld && err_any;
        refill_req = s1_vld && !cmp_uncached && !lk_hit;
        refill_way = victim;
        lk_way     = lk_hit ? match_way : 1'b0;
        rd_dw      = lk_hit ? dw_data[match_way*DW +: DW] : '0;
    end

    vipt2w_victim #(.IDX_W(IDX_W), .LOCK_WAY(LOCK_WAY)) u_vict (
        .clk(clk), .rst_n(rst_n), .idx(s1_idx),
        .way_vld(way_vld), .way_tperr(way_tperr),
        .any_match(any_match), .match_way(match_way), .err_any(err_any),
        .lock_en(lock_en), .upd_hit(lk_hit), .upd_fill(refill_req),
        .victim(victim)
    );

    // R9
    assert property (@(posedge clk) disable iff (!rst_n)
        !s1_vld |-> !lk_hit && !lk_miss && !lk_err && !refill_req) else $error("idle_quiet_chk");
    // R5
    assert property (@(posedge clk) disable iff (!rst_n)
        s1_vld && cmp_uncached |-> !refill_req && !lk_hit) else $error("uncached_no_alloc_chk");
    // R6
    assert property (@(posedge clk) disable iff (!rst_n)
        lk_err |-> !lk_hit && lk_miss) else $error("err_forces_miss_chk");
    // R1
    assert property (@(posedge clk) disable iff (!rst_n)
        lk_hit |-> !refill_req && !lk_miss) else $error("hit_no_refill_chk");
endmodule

// File: tb/tb_vipt2w_tag_ctrl.sv
`timescale 1ns/1ps
// Bench: directed corners plus a seeded random stream over a few sets and tags,
// checked against a behavioural model of tags, valid, damage and LRU state.
module tb_vipt2w_tag_ctrl;
    logic         clk = 1'b0;
    logic         rst_n = 1'b0;
    logic         req_vld = 1'b0;
    logic [7:0]   req_vidx = '0;
    logic [23:0]  cmp_ptag = '0;
    logic         cmp_uncached = 1'b0;
    logic         lock_en = 1'b0;
    logic         fill_par_flip = 1'b0;
    logic [127:0] dw_data = '0;
    logic [3:0]   dw_par = '0;
    logic         lk_hit, lk_miss, lk_way, lk_err, refill_req, refill_way;
    logic [63:0]  rd_dw;

    vipt2w_tag_ctrl dut (.*);

    always #2.5 clk = ~clk;

    int n_chk = 0;
    int n_bad = 0;

    // Bench model
    bit          m_vld [2][256];
    bit          m_bad [2][256];
    logic [23:0] m_tag [2][256];
    bit          m_lru [256];

    // Pending request, now in its compare cycle
    bit          p_act = 0, p_unc = 0, p_lock = 0, p_inj = 0;
    logic [7:0]  p_idx = '0;
    logic [23:0] p_tag = '0;
    logic [1:0]  p_dbad = '0;
    logic [63:0] p_dw0 = '0, p_dw1 = '0;

    function automatic logic [1:0] dpar(input logic [63:0] d);
        return {^d[63:32], ^d[31:0]};
    endfunction

    task automatic chk(input string rq, input string what, input logic [63:0] act, input logic [63:0] exp);
        n_chk++;
        if (act !== exp) begin
            n_bad++;
            $display("FAIL %s %s actual=%0h expected=%0h", rq, what, act, exp);
        end
    endtask

    task automatic judge_pending();
        bit tpe0, tpe1, mt0, mt1, any, mw, dpe, e, eh, erf, v;
        int i;
        i    = int'(p_idx);
        tpe0 = m_vld[0][i] && m_bad[0][i];
        tpe1 = m_vld[1][i] && m_bad[1][i];
        mt0  = m_vld[0][i] && !m_bad[0][i] && m_tag[0][i] == p_tag;
        mt1  = m_vld[1][i] && !m_bad[1][i] && m_tag[1][i] == p_tag;
        any  = mt0 || mt1;
        mw   = mt0 ? 1'b0 : 1'b1;
        dpe  = any && p_dbad[mw];
        e    = tpe0 || tpe1 || dpe;
        eh   = !p_unc && any && !e;
        erf  = !p_unc && !eh;
        if (e)                 v = any ? mw : (tpe0 ? 1'b0 : 1'b1);
        else if (p_lock)       v = 1'b1;
        else if (!m_vld[0][i]) v = 1'b0;
        else if (!m_vld[1][i]) v = 1'b1;
        else                   v = m_lru[i];
        chk(p_unc ? "R5" : "R1", "hit", 64'(lk_hit), 64'(eh));
        chk("R1", "miss", 64'(lk_miss), 64'(!eh));
        chk(dpe ? "R7" : "R6", "err", 64'(lk_err), 64'(e));
        chk(p_unc ? "R5" : "R2", "refill_req", 64'(refill_req), 64'(erf));
        if (eh) begin
            chk("R1", "hit_way", 64'(lk_way), 64'(mw));
            chk("R1", "rd_dw", rd_dw, mw ? p_dw1 : p_dw0);
        end
        if (erf) begin
            if (e)           chk((dpe && !tpe0 && !tpe1) ? "R7" : "R6", "refill_way", 64'(refill_way), 64'(v));
            else if (p_lock) chk("R4", "refill_way", 64'(refill_way), 64'(v));
            else             chk("R3", "refill_way", 64'(refill_way), 64'(v));
        end
        if (eh) m_lru[i] = ~mw;
        if (erf) begin
            m_vld[v][i] = 1'b1;
            m_tag[v][i] = p_tag;
            m_bad[v][i] = p_inj;
            m_lru[i]    = ~v;
        end
    endtask

    // One cycle: present the compare inputs of the pending lookup, issue a new one, judge.
    task automatic step(input bit act, input logic [7:0] idx, input logic [23:0] tag,
                        input bit unc, input bit lock, input bit inj, input logic [1:0] dbad);
        @(negedge clk);
        cmp_ptag      = p_tag;
        cmp_uncached  = p_unc;
        lock_en       = p_lock;
        fill_par_flip = p_inj;
        dw_data       = {p_dw1, p_dw0};
        dw_par        = {dpar(p_dw1) ^ {2{p_dbad[1]}}, dpar(p_dw0) ^ {2{p_dbad[0]}}};
        req_vld       = act;
        req_vidx      = idx;
        #1;
        if (p_act) judge_pending();
        else begin
            chk("R9", "idle_hit", 64'(lk_hit), 64'd0);
            chk("R9", "idle_miss_refill", 64'({lk_miss, lk_err, refill_req}), 64'd0);
        end
        p_act = act; p_idx = idx; p_tag = tag; p_unc = unc;
        p_lock = lock; p_inj = inj; p_dbad = dbad;
        p_dw0 = {$urandom, $urandom};
        p_dw1 = {$urandom, $urandom};
    endtask

    task automatic look(input logic [7:0] idx, input logic [23:0] tag, input bit unc,
                        input bit lock, input bit inj, input logic [1:0] dbad);
        step(1'b1, idx, tag, unc, lock, inj, dbad);
    endtask

    task automatic idle();
        step(1'b0, 8'd0, 24'd0, 1'b0, 1'b0, 1'b0, 2'b00);
    endtask

    initial begin
        repeat (200000) @(posedge clk);
        n_bad++;
        $display("FAIL watchdog expired");
        $display("*** SUMMARY: %0d compared / %0d mismatched ***", n_chk, n_bad);
        $finish;
    end

    initial begin
        void'($urandom(32'h5eed_c0de));
        repeat (3) @(posedge clk);
        @(negedge clk);
        rst_n = 1'b1;
        // R8: outputs quiet after reset, and the first lookup finds every way empty
        #1;
        chk("R8", "reset_outputs", 64'({lk_hit, lk_miss, lk_err, refill_req}), 64'd0);
        idle();
        look(8'd10, 24'hA0A0A0, 0, 0, 0, 2'b00);        // R8 miss, fill way 0
        look(8'd10, 24'hA0A0A0, 0, 0, 0, 2'b00);        // R2 back-to-back hit
        look(8'd10, 24'hB1B1B1, 0, 0, 0, 2'b00);        // R3 invalid way 1 chosen
        look(8'd10, 24'hA0A0A0, 0, 0, 0, 2'b00);        // R3 hit way 0 -> way 1 LRU
        look(8'd10, 24'hC2C2C2, 0, 0, 0, 2'b00);        // R3 replace way 1
        look(8'd10, 24'hC2C2C2, 0, 0, 0, 2'b00);        // R2 same-edge bypass
        idle();
        // R4: lock keeps way 0 resident
        look(8'd20, 24'h111111, 0, 0, 0, 2'b00);
        look(8'd20, 24'h222222, 0, 0, 0, 2'b00);
        look(8'd20, 24'h222222, 0, 0, 0, 2'b00);        // way 0 now LRU
        look(8'd20, 24'h333333, 0, 1, 0, 2'b00);        // locked: way 1 anyway
        look(8'd20, 24'h444444, 0, 1, 0, 2'b00);
        look(8'd20, 24'h111111, 0, 1, 0, 2'b00);        // still hits way 0
        // R5: uncached leaves no trace
        look(8'd30, 24'h0BEEF0, 1, 0, 0, 2'b00);
        look(8'd30, 24'h0BEEF0, 0, 0, 0, 2'b00);        // still a miss, fills way 0
        // R6: damaged tag
        look(8'd40, 24'h5A5A5A, 0, 0, 1, 2'b00);        // fill with bad parity
        look(8'd40, 24'h5A5A5A, 0, 1, 0, 2'b00);        // err, refill way 0 despite lock
        look(8'd40, 24'h5A5A5A, 0, 0, 0, 2'b00);        // clean hit
        // R7: damaged data word
        look(8'd50, 24'h777777, 0, 0, 0, 2'b00);
        look(8'd50, 24'h777777, 0, 0, 0, 2'b01);        // err, refill way 0
        look(8'd50, 24'h888888, 0, 0, 0, 2'b00);
        look(8'd50, 24'h888888, 0, 0, 0, 2'b10);        // err, refill way 1
        idle();
        // Random stream over a few sets and tags
        for (int n = 0; n < 3000; n++) begin
            logic [7:0]  ri;
            logic [23:0] rt;
            bit ru, rl, rj;
            logic [1:0]  rd;
            ri = ($urandom % 8 == 0) ? 8'd255 : 8'($urandom % 4);
            rt = 24'h100 + 24'($urandom % 5);
            ru = ($urandom % 10) == 0;
            rl = ((n / 200) % 3) == 1;
            rj = ($urandom % 30) == 0;
            rd = (($urandom % 30) == 0) ? 2'($urandom % 3 + 1) : 2'b00;
            if (($urandom % 8) == 0) idle();
            else look(ri, rt, ru, rl, rj, rd);
        end
        idle();
        idle();
        $display("*** SUMMARY: %0d compared / %0d mismatched ***", n_chk, n_bad);
        $finish;
    end
endmodule